// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo PCM from a three-wire serial audio link made of a bit clock, a frame clock and a data line. It turns each stereo frame into two parallel 24-bit words, one for the left channel and one for the right, and marks each new pair with a one-cycle valid strobe. The block runs on the master clock, which runs at 256 times the sample rate. The bit clock runs at 64 times the sample rate, so each bit lasts four master-clock cycles and each channel has a 32-bit slot. The block samples all three link wires through a short synchronizer and acts on the rising edge of the bit clock.

A 2-bit format input selects the framing: I2S, left-justified, right-justified, or DSP word-sync. A 2-bit word-length input selects 24, 20 or 16 bits. Both inputs come from a control block. Data arrive MSB first in two's complement. Words shorter than 24 bits are left-aligned in the output word, and the low bits are filled with zeros. For each channel, the block also raises a flag once that channel has carried a long run of all-zero samples.

Top module: `serial_audio_rx`

## Requirements
- R1: Format code 00 selects I2S. A frame starts when the frame clock, sampled on rising bit-clock edges, goes from 1 to 0. Frame clock low marks the left slot. Each slot's MSB is sampled one bit clock after the frame-clock change.
- R2: Format code 01 selects left-justified. A frame starts when the frame clock goes from 0 to 1. Frame clock high marks the left slot. Each slot's MSB is sampled on the bit where the frame clock changes.
- R3: Format code 10 selects right-justified, with left on frame clock high. The LSB of each channel is the last bit of its 32-bit slot, so capture starts 32−N bits into the slot, where N is the programmed word length.
- R4: Format code 11 selects DSP word-sync. A frame starts when the frame clock goes from 0 to 1, as a one-bit sync pulse. The left MSB follows on the next bit, and the right sample comes directly after the left LSB.
- R5: Word-length code 01 means 20 bits and code 10 means 16 bits. Codes 00 and 11 mean 24 bits, which is the default. A sample of N bits appears in bits 23 down to 24−N of its output word, and the bits below are zero.
- R6: `valid_o` is high for exactly one master-clock cycle after the last right-channel bit of each frame. `left_o` and `right_o` change only in that cycle, and they keep their values between pulses.
- R7: The zero flag of a channel goes high when the pair that carries that channel's ZERO_RUN-th consecutive all-zero sample is presented (default 1024). It goes low when a pair with a nonzero sample on that channel is presented. The two channels are tracked on their own.
- R8: After reset, all outputs are zero. The first rising bit-clock edge only records the frame-clock level. No pair is produced from the frame that is in progress before the first frame start recognised after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (256 × sample rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock (64 × sample rate) |
| lrck_i | input | 1 | Frame clock / frame sync |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Framing format code |
| wlen_i | input | 2 | Word-length code |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe for a new pair |
| zero_l_o | output | 1 | Left channel zero-run flag |
| zero_r_o | output | 1 | Right channel zero-run flag |

## Verification
The alignment checks assume that the format and word-length codes change only while reset is held. The bench therefore sets each configuration inside a reset pulse and never reprograms a running stream. The checks also assume a bit clock of exactly four master-clock cycles, with the frame clock and data changing near the falling bit-clock edge. The bench drives every bit that way and fills the unused slot bits with random values. The zero-flag properties compare the flags against the sample words in the same cycle, so they rely on the flags and the words being updated together with the strobe.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
  localparam int SMP_W  = 24;
  localparam int SLOT_W = 32;
  localparam int POS_W  = $clog2(2 * SLOT_W);
  localparam int WIN_W  = POS_W + 1;

  typedef enum logic [1:0] {
    FMT_I2S = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_RJ  = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;

  // Word-length code to bit count; unknown codes fall back to the full width.
  function automatic logic [5:0] word_bits(input logic [1:0] code);
    case (code)
      2'b01:   return 6'd20;
      2'b10:   return 6'd16;
      default: return 6'd24;
    endcase
  endfunction
endpackage

// File: rtl/sarx_front.sv
module sarx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic lrck_i,
  input  logic sdata_i,
  output logic bit_stb_o,
  output logic lr_o,
  output logic dat_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][2:0] pipe_q;
  logic                        bclk_last_q;

  // All three link wires travel through the same stage count, so they stay aligned.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q      <= '0;
      bclk_last_q <= 1'b0;
    end else begin
      pipe_q[0] <= {bclk_i, lrck_i, sdata_i};
      for (int i = 1; i < SYNC_STAGES; i++) begin
        pipe_q[i] <= pipe_q[i-1];
      end
      bclk_last_q <= pipe_q[LAST][2];
    end
  end

  assign bit_stb_o = pipe_q[LAST][2] & ~bclk_last_q;
  assign lr_o      = pipe_q[LAST][1];
  assign dat_o     = pipe_q[LAST][0];
endmodule

// File: rtl/sarx_slot.sv
module sarx_slot
  import sarx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb_i,
  input  logic       lr_i,
  input  logic [1:0] fmt_i,
  input  logic [5:0] nbits_i,
  output logic       cap_o,
  output logic       chan_o,
  output logic       first_o,
  output logic       last_o
);
  logic             primed_q, primed_d;
  logic             lr_prev_q, lr_prev_d;
  logic             locked_q, locked_d;
  logic [POS_W-1:0] pos_q, pos_d;

  logic             frame_start;
  logic             locked_now;
  logic [POS_W-1:0] cur_pos;
  logic [WIN_W-1:0] cur_w, n_w, start_l, start_r, base;
  logic             in_l, in_r;

  always_comb begin
    if (fmt_e'(fmt_i) == FMT_I2S) begin
      frame_start = primed_q & lr_prev_q & ~lr_i;
    end else begin
      frame_start = primed_q & ~lr_prev_q & lr_i;
    end
    locked_now = locked_q | frame_start;
    cur_pos    = frame_start ? '0 : pos_q + 1'b1;
    cur_w      = {1'b0, cur_pos};
    n_w        = WIN_W'(nbits_i);

    case (fmt_e'(fmt_i))
      FMT_LJ:  start_l = '0;
      FMT_RJ:  start_l = WIN_W'(SLOT_W) - n_w;
      default: start_l = WIN_W'(1);
    endcase
    if (fmt_e'(fmt_i) == FMT_DSP) begin
      start_r = start_l + n_w;
    end else begin
      start_r = start_l + WIN_W'(SLOT_W);
    end

    in_l   = locked_now && (cur_w >= start_l) && (cur_w < start_l + n_w);
    in_r   = locked_now && (cur_w >= start_r) && (cur_w < start_r + n_w);
    base   = in_r ? start_r : start_l;

    cap_o   = bit_stb_i & (in_l | in_r);
    chan_o  = in_r;
    first_o = (cur_w == base);
    last_o  = (cur_w == base + n_w - 1'b1);
  end

  always_comb begin
    primed_d  = primed_q;
    lr_prev_d = lr_prev_q;
    locked_d  = locked_q;
    pos_d     = pos_q;
    if (bit_stb_i) begin
      primed_d  = 1'b1;
      lr_prev_d = lr_i;
      locked_d  = locked_now;
      pos_d     = cur_pos;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q  <= 1'b0;
      lr_prev_q <= 1'b0;
      locked_q  <= 1'b0;
      pos_q     <= '0;
    end else begin
      primed_q  <= primed_d;
      lr_prev_q <= lr_prev_d;
      locked_q  <= locked_d;
      pos_q     <= pos_d;
    end
  end
endmodule

// File: rtl/sarx_assemble.sv
module sarx_assemble
  import sarx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic             chan_i,
  input  logic             first_i,
  input  logic             last_i,
  input  logic             dat_i,
  input  logic [5:0]       nbits_i,
  output logic             pair_stb_o,
  output logic [SMP_W-1:0] pair_l_o,
  output logic [SMP_W-1:0] pair_r_o,
  output logic [SMP_W-1:0] left_o,
  output logic [SMP_W-1:0] right_o,
  output logic             valid_o
);
  logic [SMP_W-1:0] acc_q, acc_d;
  logic [SMP_W-1:0] lhold_q, lhold_d;
  logic [SMP_W-1:0] left_d, right_d;
  logic             valid_d;
  logic [SMP_W-1:0] shifted, aligned;
  logic [5:0]       pad;

  always_comb begin
    shifted    = first_i ? {{(SMP_W-1){1'b0}}, dat_i} : {acc_q[SMP_W-2:0], dat_i};
    pad        = 6'(SMP_W) - nbits_i;
    aligned    = shifted << pad;
    pair_stb_o = cap_i & last_i & chan_i;
    pair_l_o   = lhold_q;
    pair_r_o   = aligned;

    acc_d   = acc_q;
    lhold_d = lhold_q;
    left_d  = left_o;
    right_d = right_o;
    valid_d = pair_stb_o;
    if (cap_i) begin
      acc_d = shifted;
    end
    if (cap_i && last_i && !chan_i) begin
      lhold_d = aligned;
    end
    if (pair_stb_o) begin
      left_d  = lhold_q;
      right_d = aligned;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      lhold_q <= '0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      lhold_q <= lhold_d;
      left_o  <= left_d;
      right_o <= right_d;
      valid_o <= valid_d;
    end
  end
endmodule

// File: rtl/sarx_zero.sv
module sarx_zero #(
  parameter int RUN   = 1024,
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_i,
  input  logic [WIDTH-1:0] smp_i,
  output logic             zero_o
);
  localparam int           CW    = $clog2(RUN + 1);
  localparam logic [CW-1:0] RUN_C = CW'(RUN);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (upd_i) begin
      if (smp_i != '0) begin
        cnt_d = '0;
      end else if (cnt_q != RUN_C) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == RUN_C);
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int ZERO_RUN    = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bclk_i,
  input  logic        lrck_i,
  input  logic        sdata_i,
  input  logic [1:0]  fmt_i,
  input  logic [1:0]  wlen_i,
  output logic [23:0] left_o,
  output logic [23:0] right_o,
  output logic        valid_o,
  output logic        zero_l_o,
  output logic        zero_r_o
);
  localparam int NCH = 2;

  logic             bit_stb, lr, dat;
  logic             cap, chan, first, last;
  logic [5:0]       nbits;
  logic             pair_stb;
  logic [SMP_W-1:0] pair_l, pair_r;
  logic [NCH-1:0][SMP_W-1:0] pair_smp;
  logic [NCH-1:0]   zflag;

  assign nbits = word_bits(wlen_i);

  sarx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n),
    .bclk_i(bclk_i), .lrck_i(lrck_i), .sdata_i(sdata_i),
    .bit_stb_o(bit_stb), .lr_o(lr), .dat_o(dat)
  );

  sarx_slot u_slot (
    .clk(clk), .rst_n(rst_n),
    .bit_stb_i(bit_stb), .lr_i(lr), .fmt_i(fmt_i), .nbits_i(nbits),
    .cap_o(cap), .chan_o(chan), .first_o(first), .last_o(last)
  );

  sarx_assemble u_asm (
    .clk(clk), .rst_n(rst_n),
    .cap_i(cap), .chan_i(chan), .first_i(first), .last_i(last),
    .dat_i(dat), .nbits_i(nbits),
    .pair_stb_o(pair_stb), .pair_l_o(pair_l), .pair_r_o(pair_r),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  assign pair_smp[0] = pair_l;
  assign pair_smp[1] = pair_r;

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_zero
      sarx_zero #(.RUN(ZERO_RUN), .WIDTH(SMP_W)) u_zero (
        .clk(clk), .rst_n(rst_n),
        .upd_i(pair_stb), .smp_i(pair_smp[ch]),
        .zero_o(zflag[ch])
      );
    end
  endgenerate

  assign zero_l_o = zflag[0];
  assign zero_r_o = zflag[1];
endmodule

// File: rtl/sarx_checker.sv
module sarx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  wlen_i,
  input logic [23:0] left_o,
  input logic [23:0] right_o,
  input logic        valid_o,
  input logic        zero_l_o,
  input logic        zero_r_o
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) // R6
    valid_o |=> !valid_o);

  AST_LEFT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) // R6
    !valid_o |-> $stable(left_o));

  AST_RIGHT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) // R6
    !valid_o |-> $stable(right_o));

  AST_ALIGN_20: assert property (@(posedge clk) disable iff (!rst_n) // R5
    (valid_o && wlen_i == 2'b01) |-> (left_o[3:0] == 4'h0 && right_o[3:0] == 4'h0));

  AST_ALIGN_16: assert property (@(posedge clk) disable iff (!rst_n) // R5
    (valid_o && wlen_i == 2'b10) |-> (left_o[7:0] == 8'h0 && right_o[7:0] == 8'h0));

  AST_ZL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) // R7
    (valid_o && left_o != 24'h0) |-> !zero_l_o);

  AST_ZR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) // R7
    (valid_o && right_o != 24'h0) |-> !zero_r_o);

  AST_ZL_RISE: assert property (@(posedge clk) disable iff (!rst_n) // R7
    $rose(zero_l_o) |-> (valid_o && left_o == 24'h0));

  AST_ZR_RISE: assert property (@(posedge clk) disable iff (!rst_n) // R7
    $rose(zero_r_o) |-> (valid_o && right_o == 24'h0));
endmodule

bind serial_audio_rx sarx_checker u_sarx_chk (
  .clk(clk), .rst_n(rst_n), .wlen_i(wlen_i),
  .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
  .zero_l_o(zero_l_o), .zero_r_o(zero_r_o)
);

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;
  localparam int ZR = 16;

  logic        clk;
  logic        rst_n;
  logic        bclk, lrck, sdata;
  logic [1:0]  fmt, wl;
  logic [23:0] left_o, right_o;
  logic        valid_o, zero_l_o, zero_r_o;

  int n_chk;
  int n_fail;
  int zcl, zcr;
  logic [23:0] ql[$];
  logic [23:0] qr[$];
  int unsigned seed_dummy;

  serial_audio_rx #(.ZERO_RUN(ZR)) u_serial_audio_rx (
    .clk(clk), .rst_n(rst_n),
    .bclk_i(bclk), .lrck_i(lrck), .sdata_i(sdata),
    .fmt_i(fmt), .wlen_i(wl),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
    .zero_l_o(zero_l_o), .zero_r_o(zero_r_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int nbits_of(input logic [1:0] c);
    if (c == 2'b01) return 20;
    if (c == 2'b10) return 16;
    return 24;
  endfunction

  function automatic logic [23:0] mask_of(input int n);
    return 24'hFFFFFF << (24 - n);
  endfunction

  function automatic string req_of(input logic [1:0] f);
    case (f)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  // Frame-clock level for bit p of a 64-bit frame.
  function automatic logic lr_at(input logic [1:0] f, input int p);
    case (f)
      2'b00:   return (p >= 32);
      2'b11:   return (p == 0);
      default: return (p < 32);
    endcase
  endfunction

  // Data bit for bit p; junk fills positions outside both sample windows.
  function automatic logic bit_at(input logic [1:0] f, input int n, input int p,
                                  input logic [23:0] l, input logic [23:0] r,
                                  input logic junk);
    int sl, sr;
    case (f)
      2'b00:   begin sl = 1;      sr = 33;     end
      2'b01:   begin sl = 0;      sr = 32;     end
      2'b10:   begin sl = 32 - n; sr = 64 - n; end
      default: begin sl = 1;      sr = 1 + n;  end
    endcase
    if (p >= sl && p < sl + n) return l[23 - (p - sl)];
    if (p >= sr && p < sr + n) return r[23 - (p - sr)];
    return junk;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // Pair monitor: compares each strobe with the oldest expected pair.
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (ql.size() == 0) begin
        check(1'b0, "R8", "pair with none expected (left)", left_o, 24'h0);
      end else begin
        logic [23:0] el, er;
        el = ql.pop_front();
        er = qr.pop_front();
        zcl = (el != 0) ? 0 : ((zcl < ZR) ? zcl + 1 : ZR);
        zcr = (er != 0) ? 0 : ((zcr < ZR) ? zcr + 1 : ZR);
        check(left_o == el,  {req_of(fmt), "/R5"}, "left sample",  left_o,  el);
        check(right_o == er, {req_of(fmt), "/R5"}, "right sample", right_o, er);
        check(zero_l_o == (zcl == ZR), "R7", "left zero flag",
              {23'h0, zero_l_o}, {23'h0, (zcl == ZR)});
        check(zero_r_o == (zcr == ZR), "R7", "right zero flag",
              {23'h0, zero_r_o}, {23'h0, (zcr == ZR)});
      end
      @(negedge clk);
      check(!valid_o, "R6", "strobe width", {23'h0, valid_o}, 24'h0);
    end
  end

  task automatic send_frame(input logic [23:0] l, input logic [23:0] r, input bit expect_pair);
    int n;
    n = nbits_of(wl);
    if (expect_pair) begin
      ql.push_back(l & mask_of(n));
      qr.push_back(r & mask_of(n));
    end
    for (int p = 0; p < 64; p++) begin
      @(negedge clk);
      bclk  = 1'b0;
      lrck  = lr_at(fmt, p);
      sdata = bit_at(fmt, n, p, l & mask_of(n), r & mask_of(n), 1'($urandom % 2));
      @(negedge clk);
      @(negedge clk);
      bclk = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic do_reset(input logic [1:0] f, input logic [1:0] w);
    @(negedge clk);
    rst_n = 1'b0;
    bclk  = 1'b0;
    lrck  = 1'b0;
    sdata = 1'b0;
    fmt   = f;
    wl    = w;
    ql.delete();
    qr.delete();
    zcl = 0;
    zcr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(left_o == 0 && right_o == 0, "R8", "outputs after reset",
          left_o | right_o, 24'h0);
    check(!valid_o && !zero_l_o && !zero_r_o, "R8", "strobe/flags after reset",
          {21'h0, valid_o, zero_l_o, zero_r_o}, 24'h0);
  endtask

  task automatic drain();
    repeat (40) @(negedge clk);
    check(ql.size() == 0, "R6", "pairs still missing",
          24'(ql.size()), 24'h0);
  endtask

  task automatic run_combo(input logic [1:0] f, input logic [1:0] w);
    do_reset(f, w);
    send_frame(24'h123456, 24'h654321, 1'b0);   // warm-up frame, no output (R8)
    send_frame(24'h800000, 24'h7FFFFF, 1'b1);
    send_frame(24'hFFFFFF, 24'h000001 << (24 - nbits_of(w)), 1'b1);
    send_frame(24'hAAAAAA, 24'h555555, 1'b1);
    for (int i = 0; i < 5; i++) begin
      send_frame(24'($urandom), 24'($urandom), 1'b1);
    end
    drain();
  endtask

  initial begin
    n_chk  = 0;
    n_fail = 0;
    zcl    = 0;
    zcr    = 0;
    seed_dummy = $urandom(32'h1d2c);
    rst_n = 1'b0;
    bclk  = 1'b0;
    lrck  = 1'b0;
    sdata = 1'b0;
    fmt   = 2'b00;
    wl    = 2'b00;
    repeat (3) @(negedge clk);
    check(left_o == 0 && right_o == 0 && !valid_o, "R8", "outputs in reset",
          left_o | right_o, 24'h0);

    for (int f = 0; f < 4; f++) begin
      for (int w = 0; w < 4; w++) begin
        run_combo(2'(f), 2'(w));
      end
    end

    // Zero-run behaviour, left-justified, 24 bits (R7)
    do_reset(2'b01, 2'b00);
    send_frame(24'h0, 24'h0, 1'b0);
    for (int i = 0; i < ZR - 1; i++) begin
      send_frame(24'h0, 24'($urandom) | 24'h800000, 1'b1);
    end
    drain();
    check(!zero_l_o, "R7", "left flag one short of run", {23'h0, zero_l_o}, 24'h0);
    send_frame(24'h0, 24'h400000, 1'b1);
    drain();
    check(zero_l_o && !zero_r_o, "R7", "left flag at run length",
          {22'h0, zero_l_o, zero_r_o}, 24'h2);
    for (int i = 0; i < ZR; i++) begin
      send_frame(24'h0, 24'h0, 1'b1);
    end
    drain();
    check(zero_l_o && zero_r_o, "R7", "both flags set",
          {22'h0, zero_l_o, zero_r_o}, 24'h3);
    send_frame(24'h000100, 24'h0, 1'b1);
    drain();
    check(!zero_l_o && zero_r_o, "R7", "left cleared by nonzero, right kept",
          {22'h0, zero_l_o, zero_r_o}, 24'h1);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule